// File: doc/BRIEF.md
# Instruction Abort Capture Controller

This block sits next to a small processor sequencer and turns an active-low abort request into a deferred interrupt. The abort line is sampled at every rising clock edge. Once a low level is seen, the block holds the abort as pending and blocks every register write-back for the rest of the current instruction. It does not cut the instruction short. The interrupt request is raised only when the sequencer signals that the instruction has ended.

The sequencer runs the interrupt sequence itself. It acknowledges the request, and the block then drives a two-cycle vector fetch. The fetch supplies the low byte of the vector and then the high byte, with a vector-pull strobe asserted for both reads. The mode flag picks one of two vector pairs. The return address the block reports is the address of the aborted opcode, not the address of the next instruction. That address is captured in the first cycle of every instruction, so it is correct even when the abort arrives late.

Top module: `abort_capture_ctrl`

## Requirements
- R1: After a synchronous active-low reset, and with `abort_n` high, `abort_irq`, `wr_inhibit` and `vec_pull` are 0 and `vec_addr` is 0.
- R2: `abort_n` low at a rising edge registers an abort. `wr_inhibit` is already 1 in the cycle the low level is presented, and it stays 1 until the request is acknowledged.
- R3: `abort_irq` rises only after a rising edge at which `instr_end` is 1 while an abort is pending, or is being registered at that same edge. It never rises before the instruction ends.
- R4: `ret_addr` equals the value of `op_addr` in the first cycle of the aborted instruction, even if `op_addr` changes later. The first cycle is the cycle after reset, after an `instr_end` edge, or after a vector fetch completes.
- R5: Abort requests that arrive while an abort is pending, requested or being vectored are ignored. Exactly one request and one vector fetch result.
- R6: `abort_irq` stays 1 until `irq_ack` is 1 at a rising edge. The acknowledgement clears the request and drops `wr_inhibit`.
- R7: In the two cycles after the acknowledging edge, `vec_pull` is 1. `vec_addr` gives the low byte address first and then the high byte address (bit 0 set). `vec_pull` then returns to 0.
- R8: If `emu_mode` is 1 at the edge where the request is raised, the vector pair is 0x00FFF8/0x00FFF9. If it is 0, the pair is 0x00FFE8/0x00FFE9. Later changes of `emu_mode` have no effect on that fetch.
- R9: Without an abort, `wr_inhibit` and `abort_irq` stay 0 across instruction boundaries. `irq_ack` with no request pending produces no vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_n | input | 1 | Active-low abort request, sampled every rising edge |
| instr_end | input | 1 | Strobe: current instruction finishes at this edge |
| op_addr | input | 24 | Address of the current instruction's opcode |
| emu_mode | input | 1 | 1 selects the emulation vector pair, 0 the native pair |
| irq_ack | input | 1 | Sequencer accepts the interrupt request |
| wr_inhibit | output | 1 | Blocks register write-back while an abort is in flight |
| abort_irq | output | 1 | Interrupt request to the sequencer |
| ret_addr | output | 24 | Address of the aborted opcode |
| vec_pull | output | 1 | Marks the two vector byte reads |
| vec_addr | output | 24 | Vector byte address during the fetch, 0 otherwise |

## Verification
`wr_inhibit` responds in the same cycle the low abort level is driven. Every other result changes one rising edge after its cause. `abort_irq` and `ret_addr` follow the `instr_end` edge, `vec_pull` with the low byte address follows the acknowledging edge, and the high byte address appears one edge later. The bench drives inputs on falling edges. It samples the same-cycle inhibit before the next rising edge, and samples every registered result at the falling edge after the edge that produces it, walking the fetch one edge at a time.

// File: rtl/abt_pkg.sv
// Package: shared state encoding for the abort capture controller.
// Assumes: nothing beyond 1800-2017 enums.
package abt_pkg;

    // Controller phases, from idle through the two vector byte reads
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PEND   = 3'd1,
        ST_REQ    = 3'd2,
        ST_VEC_LO = 3'd3,
        ST_VEC_HI = 3'd4
    } abt_state_e;

endpackage

// File: rtl/abt_ret_capture.sv
// Module: abt_ret_capture
// Records the opcode address in the first cycle of every instruction and
// latches the return address when the controller registers an abort.
// Assumes: op_addr is valid in the first cycle of each instruction; new_instr
// marks the edge after which the next cycle is a first cycle.
module abt_ret_capture #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_instr,
    input  logic              load_ret,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [ADDR_W-1:0] ret_addr
);

    logic              first_q;
    logic [ADDR_W-1:0] op_cap_q;
    logic [ADDR_W-1:0] cur_op;
    logic [ADDR_W-1:0] ret_q;

    // Marks the first cycle of an instruction
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= new_instr;
    end

    // Holds the opcode address seen in the first cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       op_cap_q <= '0;
        else if (first_q) op_cap_q <= op_addr;
    end

    // In the first cycle the live address is the opcode address
    always_comb begin
        cur_op = first_q ? op_addr : op_cap_q;
    end

    // Freezes the return address when an abort is registered
    always_ff @(posedge clk) begin
        if (!rst_n)        ret_q <= '0;
        else if (load_ret) ret_q <= cur_op;
    end

    assign ret_addr = ret_q;

endmodule

// File: rtl/abt_fsm.sv
// Module: abt_fsm
// Tracks an abort from registration through the request to the two vector
// reads. Gates register write-back while an abort is in flight.
// Assumes: abort_n is synchronous to clk; irq_ack is only meaningful while
// the request is up.
module abt_fsm
    import abt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_n,
    input  logic instr_end,
    input  logic irq_ack,
    output logic wr_inhibit,
    output logic abort_irq,
    output logic load_ret,
    output logic enter_req,
    output logic new_instr,
    output logic vec_pull,
    output logic vec_hi
);

    abt_state_e state_q;
    abt_state_e state_d;
    logic       abort_hit;

    assign abort_hit = ~abort_n;

    // Next-state selection; aborts are only taken while idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (abort_hit) state_d = instr_end ? ST_REQ : ST_PEND;
            ST_PEND:   if (instr_end) state_d = ST_REQ;
            ST_REQ:    if (irq_ack)   state_d = ST_VEC_LO;
            ST_VEC_LO: state_d = ST_VEC_HI;
            ST_VEC_HI: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded strobes and outputs
    always_comb begin
        load_ret   = (state_q == ST_IDLE) && abort_hit;
        enter_req  = (state_d == ST_REQ) && (state_q != ST_REQ);
        new_instr  = instr_end || (state_q == ST_VEC_HI);
        wr_inhibit = load_ret || (state_q == ST_PEND) || (state_q == ST_REQ);
        abort_irq  = (state_q == ST_REQ);
        vec_pull   = (state_q == ST_VEC_LO) || (state_q == ST_VEC_HI);
        vec_hi     = (state_q == ST_VEC_HI);
    end

    // R6: request held until acknowledged
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_irq && !irq_ack) |=> abort_irq);

    // R3: request only rises after an instruction end
    a_r3_irq_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_irq) |-> $past(instr_end));

    // R2: inhibit holds until the acknowledgement
    a_r2_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && !irq_ack) |=> wr_inhibit);

    // R5: after the request is taken, the next step is the fetch, never a new request
    a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_irq && irq_ack) |=> (!abort_irq && vec_pull));

endmodule

// File: rtl/abt_vector_gen.sv
// Module: abt_vector_gen
// Latches the mode when the request is raised and forms the vector byte
// addresses during the two fetch cycles.
// Assumes: the two base parameters are even, so bit 0 selects the byte.
module abt_vector_gen #(
    parameter int              ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] EMU_BASE = 24'h00FFF8,
    parameter logic [ADDR_W-1:0] NAT_BASE = 24'h00FFE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic              emu_mode,
    input  logic              vec_pull,
    input  logic              vec_hi,
    output logic [ADDR_W-1:0] vec_addr
);

    localparam logic [ADDR_W-1:0] BYTE_SEL = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic mode_q;

    // Mode captured at the edge that raises the request
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= 1'b0;
        else if (enter_req) mode_q <= emu_mode;
    end

    // Vector byte address, driven only during the fetch
    always_comb begin
        if (vec_pull) vec_addr = (mode_q ? EMU_BASE : NAT_BASE) | (vec_hi ? BYTE_SEL : '0);
        else          vec_addr = '0;
    end

    // R7: the fetch lasts two cycles, low byte then high byte
    a_r7_pull_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_pull) |=> (vec_pull && vec_addr[0]));

    // R8: both reads of one fetch use the same vector pair
    a_r8_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pull && $past(vec_pull)) |-> (vec_addr[ADDR_W-1:1] == $past(vec_addr[ADDR_W-1:1])));

endmodule

// File: rtl/abort_capture_ctrl.sv
// Module: abort_capture_ctrl
// Top level. Registers an active-low abort, inhibits write-back for the
// remaining instruction, requests an interrupt at the instruction end and
// supplies the aborted opcode address and the mode-selected vector.
// Assumes: the sequencer drives instr_end for one cycle per instruction and
// runs the interrupt sequence after irq_ack.
module abort_capture_ctrl #(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] EMU_BASE = 24'h00FFF8,
    parameter logic [ADDR_W-1:0] NAT_BASE = 24'h00FFE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_n,
    input  logic              instr_end,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              emu_mode,
    input  logic              irq_ack,
    output logic              wr_inhibit,
    output logic              abort_irq,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              vec_pull,
    output logic [ADDR_W-1:0] vec_addr
);

    logic load_ret;
    logic enter_req;
    logic new_instr;
    logic vec_hi;

    abt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_n    (abort_n),
        .instr_end  (instr_end),
        .irq_ack    (irq_ack),
        .wr_inhibit (wr_inhibit),
        .abort_irq  (abort_irq),
        .load_ret   (load_ret),
        .enter_req  (enter_req),
        .new_instr  (new_instr),
        .vec_pull   (vec_pull),
        .vec_hi     (vec_hi)
    );

    abt_ret_capture #(.ADDR_W(ADDR_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_instr (new_instr),
        .load_ret  (load_ret),
        .op_addr   (op_addr),
        .ret_addr  (ret_addr)
    );

    abt_vector_gen #(.ADDR_W(ADDR_W), .EMU_BASE(EMU_BASE), .NAT_BASE(NAT_BASE)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_req),
        .emu_mode  (emu_mode),
        .vec_pull  (vec_pull),
        .vec_hi    (vec_hi),
        .vec_addr  (vec_addr)
    );

    // R4: the return address does not move while the request waits
    a_r4_ret_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_irq && !irq_ack) |=> $stable(ret_addr));

endmodule

// File: tb/abort_capture_ctrl_tb.sv
module abort_capture_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        abort_n;
    logic        instr_end;
    logic [23:0] op_addr;
    logic        emu_mode;
    logic        irq_ack;
    logic        wr_inhibit;
    logic        abort_irq;
    logic [23:0] ret_addr;
    logic        vec_pull;
    logic [23:0] vec_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    abort_capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .instr_end(instr_end),
        .op_addr(op_addr), .emu_mode(emu_mode), .irq_ack(irq_ack),
        .wr_inhibit(wr_inhibit), .abort_irq(abort_irq), .ret_addr(ret_addr),
        .vec_pull(vec_pull), .vec_addr(vec_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One rising edge, then return at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // End the current instruction and present a new opcode address
    task automatic new_instr(input logic [23:0] a);
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        op_addr   = a;
        step();
    endtask

    // Acknowledge and walk the two vector reads
    task automatic do_fetch(input string tag, input logic [23:0] base);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk({tag, " R7 pull lo"}, vec_pull, 1);
        chk({tag, " R8 addr lo"}, vec_addr, base);
        chk({tag, " R6 irq cleared"}, abort_irq, 0);
        chk({tag, " R6 inhibit cleared"}, wr_inhibit, 0);
        step();
        chk({tag, " R7 pull hi"}, vec_pull, 1);
        chk({tag, " R8 addr hi"}, vec_addr, base | 24'h1);
        step();
        chk({tag, " R7 pull end"}, vec_pull, 0);
        chk({tag, " R7 addr idle"}, vec_addr, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; abort_n = 1'b1; instr_end = 1'b0; op_addr = '0;
        emu_mode = 1'b1; irq_ack = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R1 irq", abort_irq, 0);
        chk("R1 inhibit", wr_inhibit, 0);
        chk("R1 pull", vec_pull, 0);
        chk("R1 vec", vec_addr, 0);
    endtask

    task automatic t_no_abort();
        new_instr(24'h001000);
        step();
        new_instr(24'h001004);
        chk("R9 inhibit", wr_inhibit, 0);
        chk("R9 irq", abort_irq, 0);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R9 stray ack pull", vec_pull, 0);
        step();
        chk("R9 stray ack irq", abort_irq, 0);
    endtask

    task automatic t_late_abort_emu();
        new_instr(24'h012340);
        op_addr = 24'h012341;
        step();
        op_addr = 24'h012342;
        abort_n = 1'b0;
        #1;
        chk("R2 same-cycle inhibit", wr_inhibit, 1);
        step();
        abort_n = 1'b1;
        chk("R2 inhibit held", wr_inhibit, 1);
        chk("R3 no irq before end", abort_irq, 0);
        step();
        chk("R3 still waiting", abort_irq, 0);
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        chk("R3 irq after end", abort_irq, 1);
        chk("R4 ret addr late abort", ret_addr, 24'h012340);
        emu_mode = 1'b0;
        step(); step();
        chk("R6 irq held", abort_irq, 1);
        chk("R2 inhibit until ack", wr_inhibit, 1);
        do_fetch("emu", 24'h00FFF8);
        emu_mode = 1'b1;
    endtask

    task automatic t_native_first_cycle();
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        op_addr   = 24'h0ABC00;
        abort_n   = 1'b0;
        emu_mode  = 1'b0;
        step();
        abort_n = 1'b1;
        op_addr = 24'h0ABC01;
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        emu_mode  = 1'b1;
        chk("R4 ret first-cycle abort", ret_addr, 24'h0ABC00);
        chk("R3 irq native", abort_irq, 1);
        do_fetch("native", 24'h00FFE8);
    endtask

    task automatic t_abort_on_end();
        new_instr(24'h055500);
        op_addr = 24'h055503;
        step();
        abort_n = 1'b0; instr_end = 1'b1;
        step();
        abort_n = 1'b1; instr_end = 1'b0;
        chk("R3 irq same-edge", abort_irq, 1);
        chk("R4 ret same-edge", ret_addr, 24'h055500);
        do_fetch("same-edge", 24'h00FFF8);
    endtask

    task automatic t_double_abort();
        new_instr(24'h077700);
        abort_n = 1'b0;
        step();
        abort_n = 1'b1;
        op_addr = 24'h077702;
        step();
        abort_n = 1'b0;
        step();
        abort_n = 1'b1;
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        abort_n = 1'b0;
        step();
        chk("R5 ret kept", ret_addr, 24'h077700);
        abort_n = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        abort_n = 1'b0;
        chk("R5 fetch lo", vec_pull, 1);
        step();
        abort_n = 1'b1;
        chk("R5 fetch hi", vec_addr, 24'h00FFF9);
        step();
        chk("R5 no second irq", abort_irq, 0);
        chk("R5 no inhibit", wr_inhibit, 0);
        step(); step();
        chk("R5 still no irq", abort_irq, 0);
        chk("R5 no pull", vec_pull, 0);
    endtask

    initial begin
        t_reset();
        t_no_abort();
        t_late_abort_emu();
        t_native_first_cycle();
        t_abort_on_end();
        t_double_abort();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule